// File: doc/BRIEF.md
# Two-Phase Addressed Word Memory

This block is a synchronous word memory whose address reaches it in two halves over one narrow bus. A row strobe captures the upper half of the address and a later column strobe captures the lower half. The words sit in a square grid. One small decoder turns the row half into a one-hot row line, and a second turns the column half into a one-hot column line. A word is selected only where the active row line meets the active column line, so no full-width decoder is needed. With the default parameters the grid is 32 by 32 words of 16 bits, addressed through a 5-bit bus.

Once both halves are held, a single read or write pulse uses them and then releases them. The next access needs a fresh pair of strobes. Read data is registered and stays on the output until the next accepted read. A refresh request, honoured only while no address half is held, steps a row counter through the grid and wraps at the last row. Refresh leaves stored words unchanged. Raising read and write together performs neither and pulses an error flag.

Top module: `mux_addr_ram`

## Requirements
- R1: After reset, `rd_data` is 0, `err` is 0, `refresh_row` is 0 and no address half is held.
- R2: A row strobe captures `addr_bus` as the row half and discards any column half already held. A column strobe captures the column half only when a row half is already held.
- R3: An accepted write stores `wr_data` in the word at row `r` and column `c`, where `r` is the captured row half and `c` is the captured column half. In the bench, the linear word index is `r*COLS + c`.
- R4: An accepted read places the selected word on `rd_data` at the clock edge where `rd_en` is sampled. `rd_data` then keeps that value until the next accepted read.
- R5: A read or write raised while the two halves are not both held is ignored. No word changes and `rd_data` keeps its value.
- R6: An accepted read or write releases both halves. A second access without new strobes is ignored.
- R7: When `rd_en` and `wr_en` are high in the same cycle, neither access happens. `err` is 1 for exactly the following cycle, and the held halves are kept.
- R8: A refresh request is accepted when no half is held and there is no row strobe, read or write in that cycle. An accepted request adds one to `refresh_row`, and the count wraps from `ROWS-1` to 0.
- R9: A refresh request is ignored while a row half is held. Refresh never changes any stored word.
- R10: Row and column strobes are ignored in any cycle in which `rd_en` or `wr_en` is high.
- R11: When both strobes are high in the same cycle, only the row strobe takes effect and no column half is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_bus | input | HALF_W | Shared address half, row or column |
| row_stb | input | 1 | Capture the row half |
| col_stb | input | 1 | Capture the column half |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Data to store |
| refresh_req | input | 1 | Refresh step request |
| rd_data | output | DATA_W | Registered read data |
| err | output | 1 | Read and write were raised together |
| refresh_row | output | HALF_W | Next row to refresh |

## Verification
The bench builds the block with HALF_W=3 and DATA_W=8, which gives an 8-by-8 grid of 64 words. At that size every row and column decode line is exercised and every word is written and read back in a single sweep. The refresh counter wraps after eight accepted requests, so the wrap is reached quickly and can be checked again many times during a long run of random strobe, access and refresh traffic.

// File: rtl/mux_addr_ram.sv
module mux_addr_ram #(
  parameter int HALF_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] addr_bus,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              refresh_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic [HALF_W-1:0] refresh_row
);
  localparam int ROWS = 1 << HALF_W;
  localparam int COLS = ROWS;

  logic [HALF_W-1:0] row_q, col_q;
  logic              row_ok, col_ok;
  logic [ROWS-1:0]   row_sel;
  logic [COLS-1:0]   col_sel;
  logic [DATA_W-1:0] mem [ROWS][COLS];
  logic [DATA_W-1:0] sel_word;

  wire any_acc  = rd_en | wr_en;
  wire clash    = rd_en & wr_en;
  wire armed    = row_ok & col_ok;
  wire do_wr    = wr_en & ~rd_en & armed;
  wire do_rd    = rd_en & ~wr_en & armed;
  wire take_row = row_stb & ~any_acc;
  wire take_col = col_stb & ~row_stb & ~any_acc & row_ok;
  wire take_ref = refresh_req & ~row_stb & ~any_acc & ~row_ok;

  assign row_sel = ROWS'(1) << row_q;
  assign col_sel = COLS'(1) << col_q;

  always_comb begin
    sel_word = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (row_sel[r] && col_sel[c]) sel_word = sel_word | mem[r][c];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (do_wr && row_sel[r] && col_sel[c]) mem[r][c] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q       <= '0;
      col_q       <= '0;
      row_ok      <= 1'b0;
      col_ok      <= 1'b0;
      rd_data     <= '0;
      err         <= 1'b0;
      refresh_row <= '0;
    end else begin
      err <= clash;
      if (do_rd) rd_data <= sel_word;
      if (do_rd || do_wr) begin
        row_ok <= 1'b0;
        col_ok <= 1'b0;
      end else if (take_row) begin
        row_q  <= addr_bus;
        row_ok <= 1'b1;
        col_ok <= 1'b0;
      end else if (take_col) begin
        col_q  <= addr_bus;
        col_ok <= 1'b1;
      end
      if (take_ref) refresh_row <= refresh_row + 1'b1;
    end
  end

  p_col_needs_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_ok |-> row_ok);

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rd_data));

  p_unarmed_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !armed) |=> $stable(rd_data) && $stable(row_ok));

  p_access_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd || do_wr) |=> !row_ok && !col_ok);

  p_clash_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> err && $stable(rd_data) && $stable(col_ok));

  p_ref_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ref && refresh_row == HALF_W'(ROWS-1)) |=> refresh_row == '0);

  p_ref_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_ok |=> $stable(refresh_row));
endmodule

// File: tb/tb_mux_addr_ram.sv
module tb_mux_addr_ram;
  localparam int HW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] addr_bus = '0;
  logic          row_stb = 0, col_stb = 0, rd_en = 0, wr_en = 0, refresh_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          err;
  logic [HW-1:0] refresh_row;

  int vectors = 0, misses = 0;
  bit done = 0;

  int m_mem [N*N];
  int m_rd, m_ref, m_row, m_col;
  bit m_err, m_rv, m_cv;

  mux_addr_ram #(.HALF_W(HW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_bus(addr_bus), .row_stb(row_stb),
    .col_stb(col_stb), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .refresh_req(refresh_req), .rd_data(rd_data), .err(err),
    .refresh_row(refresh_row));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rd <= 0; m_err <= 0; m_ref <= 0; m_rv <= 0; m_cv <= 0;
    end else begin
      m_err <= rd_en && wr_en;
      if (rd_en || wr_en) begin
        if (!(rd_en && wr_en) && m_rv && m_cv) begin
          if (wr_en) m_mem[m_row*N + m_col] <= int'(wr_data);
          else       m_rd <= m_mem[m_row*N + m_col];
          m_rv <= 0; m_cv <= 0;
        end
      end else if (row_stb) begin
        m_row <= int'(addr_bus); m_rv <= 1; m_cv <= 0;
      end else if (col_stb && m_rv) begin
        m_col <= int'(addr_bus); m_cv <= 1;
      end else if (refresh_req && !m_rv) begin
        m_ref <= (m_ref + 1) % N;
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R4 rd_data vs model", int'(rd_data), m_rd);
    check("R7 err vs model", int'(err), int'(m_err));
    check("R8 refresh_row vs model", int'(refresh_row), m_ref);
  end

  task automatic tick;
    @(posedge clk); #3;
  endtask

  task automatic put_addr(int r, int c);
    addr_bus = HW'(r); row_stb = 1; tick; row_stb = 0;
    addr_bus = HW'(c); col_stb = 1; tick; col_stb = 0;
  endtask

  task automatic do_write(int r, int c, int d);
    put_addr(r, c);
    wr_en = 1; wr_data = DW'(d); tick; wr_en = 0;
  endtask

  task automatic do_read(int r, int c);
    put_addr(r, c);
    rd_en = 1; tick; rd_en = 0;
  endtask

  function automatic int pat(int r, int c);
    return ((r*N + c) * 37 + 11) & 8'hFF;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      misses++; vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    check("R1 reset rd_data", int'(rd_data), 0);
    check("R1 reset err", int'(err), 0);
    check("R1 reset refresh_row", int'(refresh_row), 0);

    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) do_write(r, c, pat(r, c));
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        do_read(r, c);
        check("R3 stored word", int'(rd_data), pat(r, c));
      end

    tick; tick; tick;
    check("R4 read data held", int'(rd_data), pat(N-1, N-1));

    wr_en = 1; wr_data = 8'hAA; tick; wr_en = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R5 unarmed read ignored", int'(rd_data), pat(N-1, N-1));
    do_read(N-1, N-1);
    check("R5 unarmed write ignored", int'(rd_data), pat(N-1, N-1));

    do_write(1, 2, 8'h5C);
    wr_en = 1; wr_data = 8'h33; tick; wr_en = 0;
    do_read(1, 2);
    check("R6 second write without strobes ignored", int'(rd_data), 8'h5C);

    put_addr(2, 3);
    rd_en = 1; wr_en = 1; wr_data = 8'h55; tick; rd_en = 0; wr_en = 0;
    check("R7 err after clash", int'(err), 1);
    tick;
    check("R7 err falls", int'(err), 0);
    rd_en = 1; tick; rd_en = 0;
    check("R7 halves kept, no write", int'(rd_data), pat(2, 3));

    addr_bus = 3'd4; row_stb = 1; tick; addr_bus = 3'd5; tick; row_stb = 0;
    addr_bus = 3'd6; col_stb = 1; tick; col_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R2 latest row strobe wins", int'(rd_data), pat(5, 6));
    put_addr(1, 2);
    addr_bus = 3'd3; row_stb = 1; tick; row_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R2 new row discards column", int'(rd_data), pat(5, 6));
    addr_bus = 3'd1; col_stb = 1; tick; col_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R2 column after row", int'(rd_data), pat(3, 1));

    addr_bus = 3'd4; row_stb = 1; col_stb = 1; tick; row_stb = 0; col_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R11 joint strobes capture no column", int'(rd_data), pat(3, 1));
    addr_bus = 3'd6; col_stb = 1; tick; col_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R11 row from joint strobe", int'(rd_data), pat(4, 6));

    addr_bus = 3'd2; row_stb = 1; tick; row_stb = 0;
    addr_bus = 3'd7; col_stb = 1; rd_en = 1; tick; col_stb = 0; rd_en = 0;
    check("R10 strobe with read ignored", int'(rd_data), pat(4, 6));
    addr_bus = 3'd1; col_stb = 1; tick; col_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R10 later column used", int'(rd_data), pat(2, 1));

    for (int i = 0; i < N - 1; i++) begin refresh_req = 1; tick; end
    refresh_req = 0;
    check("R8 refresh count", int'(refresh_row), N - 1);
    refresh_req = 1; tick; tick; refresh_req = 0;
    check("R8 refresh wrap", int'(refresh_row), 1);

    addr_bus = 3'd0; row_stb = 1; tick; row_stb = 0;
    refresh_req = 1; tick; tick; refresh_req = 0;
    check("R9 refresh blocked by held row", int'(refresh_row), 1);
    addr_bus = 3'd0; col_stb = 1; tick; col_stb = 0;
    rd_en = 1; tick; rd_en = 0;
    check("R9 contents after refresh", int'(rd_data), pat(0, 0));

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 99);
      addr_bus    = HW'($urandom);
      wr_data     = DW'($urandom);
      row_stb     = (k < 20);
      col_stb     = (k >= 15 && k < 40);
      rd_en       = (k >= 38 && k < 55) || (k == 99);
      wr_en       = (k >= 55 && k < 70) || (k == 99);
      refresh_req = (k >= 65 && k < 90);
      tick;
    end
    row_stb = 0; col_stb = 0; rd_en = 0; wr_en = 0; refresh_req = 0;
    tick;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule